// File: doc/BRIEF.md
# Peripheral Reset Sequencer

This unit drives reset lines into a set of peripheral domains under control of a small word-wide register interface. Each hardware-sequenced domain has a request bit and a completion flag. Software sets a request. The unit then waits a programmable number of cycles, asserts that domain's reset for a programmable number of cycles, releases it, and raises the completion flag without further software action. Every domain has its own timing register that holds the wait and hold counts, and all domains run independently of one another.

A second register holds plain software-driven reset lines. Software asserts a line, waits, and then writes the release value. The polarity of each line is fixed at build time, so some lines are asserted by a 0 and others by a 1. Both control registers use a write-enable mask in their upper half, so a single write can change one bit without first reading the register.

Register map, in word addresses: 0 is the control register, 1 is the software line register, and 2+i is the timing register of domain i.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After power-on reset, every domain reset and software reset output is deasserted and every completion flag is 0. The control register reads 0, each timing register reads 0x00080400 (wait 4, hold 8), and the software register reads SW_ACT_LOW (0x0F by default).
- R2: In the control register, a write changes request bit n (n below NUM_DOM) only when data bit n+16 is 1. With bit n+16 at 0, no sequence starts.
- R3: A request written at clock edge W asserts dom_rst[i] from edge W+1+Dw. It holds the reset for Dh cycles and releases it at edge W+1+Dw+Dh, where Dw and Dh are the effective wait and hold counts of that domain.
- R4: dom_done[i] (control bit 28+i) becomes 1 at the same edge as the release and stays 1. Writing 0 to that bit leaves it unchanged.
- R5: Writing 1 to control bit 28+i clears only that completion flag.
- R6: A request bit reads 1 for the single cycle after its write and clears itself when the sequence leaves idle.
- R7: A request written while that domain's sequence is still running, up to and including its release edge, is ignored. No extra pulse follows and the request bit stays 0. A request written after the release starts a new sequence.
- R8: A wait or hold count of 0 acts as 1 cycle, so the reset pulse is never lost.
- R9: Timing register i holds the wait count at bits 11:8 and the hold count at bits 19:16. All other bits read 0 and ignore writes.
- R10: Software register bit n (n below NUM_SW) changes only when data bit n+16 is 1. Output sw_rst[n] is asserted when the stored bit is 0 for lines set in SW_ACT_LOW, and when it is 1 for the other lines. An unmasked write changes no output.
- R11: Domains requested in the same write run their sequences concurrently, each with its own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| dom_rst | output | NUM_DOM | Active-high reset per sequenced domain |
| dom_done | output | NUM_DOM | Completion flag per domain |
| sw_rst | output | NUM_SW | Active-high software reset lines |

## Verification
Sequences are started with the default counts, with a custom wait/hold pair, and with both counts at zero. The exact assert and release cycles therefore separate an off-by-one in either phase from a missing minimum clamp. Two domains are started in one write to show that their timers do not interfere. A repeat request during the hold phase distinguishes a correctly ignored request from one that is queued or that restarts the sequence. Masked and unmasked writes to both control registers, together with writes of 0 and 1 to the completion bits, tell the mask logic apart from plain write and write-one-to-clear behaviour.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int DATA_W   = 32;
  localparam int MASK_OFS = 16;   // write-enable half of masked registers
  localparam int DLY_LSB  = 8;    // wait count field in a timing register
  localparam int HOLD_LSB = 16;   // hold count field in a timing register

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_HOLD = 2'd2
  } sq_state_e;
endpackage

// File: rtl/rst_seq_unit.sv
// One domain's wait / hold / release sequencer.
module rst_seq_unit
  import rstseq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             rst_o,
  output logic             fin_o
);
  sq_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // load value for a phase: a zero count still gives one cycle
  function automatic logic [CNT_W-1:0] first_cnt(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    start_o = 1'b0;
    fin_o   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (req_i) begin
          st_d    = SQ_WAIT;
          cnt_d   = first_cnt(dly_i);
          cnt_en  = 1'b1;
          start_o = 1'b1;
        end
      end
      SQ_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          st_d  = SQ_HOLD;
          cnt_d = first_cnt(hold_i);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_HOLD: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          st_d  = SQ_IDLE;
          fin_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = (st_q != SQ_IDLE);
  assign rst_o  = (st_q == SQ_HOLD);
endmodule

// File: rtl/rst_ctrl_reg.sv
// Request bits (masked, self-clearing) and completion flags (write-one-to-clear).
module rst_ctrl_reg #(
  parameter int NUM_DOM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_DOM-1:0] req_data,
  input  logic [NUM_DOM-1:0] req_mask,
  input  logic [NUM_DOM-1:0] done_clr,
  input  logic [NUM_DOM-1:0] busy_i,
  input  logic [NUM_DOM-1:0] start_i,
  input  logic [NUM_DOM-1:0] fin_i,
  output logic [NUM_DOM-1:0] req_q,
  output logic [NUM_DOM-1:0] done_q
);
  logic [NUM_DOM-1:0] req_d, done_d;
  logic               upd_en;

  always_comb begin
    for (int i = 0; i < NUM_DOM; i++) begin
      req_d[i] = req_q[i];
      if (wr_en && req_mask[i]) req_d[i] = req_data[i] & ~busy_i[i];
      if (start_i[i]) req_d[i] = 1'b0;
      done_d[i] = done_q[i];
      if (wr_en && done_clr[i]) done_d[i] = 1'b0;
      if (fin_i[i]) done_d[i] = 1'b1;
    end
  end

  assign upd_en = wr_en | (|start_i) | (|fin_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      done_q <= '0;
    end else if (upd_en) begin
      req_q  <= req_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/rst_tim_reg.sv
// Per-domain wait/hold counts.
module rst_tim_reg #(
  parameter int CNT_W    = 4,
  parameter int DLY_RST  = 4,
  parameter int HOLD_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] dly_wr,
  input  logic [CNT_W-1:0] hold_wr,
  output logic [CNT_W-1:0] dly_q,
  output logic [CNT_W-1:0] hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= CNT_W'(DLY_RST);
      hold_q <= CNT_W'(HOLD_RST);
    end else if (wr_en) begin
      dly_q  <= dly_wr;
      hold_q <= hold_wr;
    end
  end
endmodule

// File: rtl/rst_sw_reg.sv
// Software-driven reset lines with per-line fixed polarity.
module rst_sw_reg #(
  parameter int          NUM_SW     = 8,
  parameter logic [15:0] SW_ACT_LOW = 16'h000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_SW-1:0] sw_data,
  input  logic [NUM_SW-1:0] sw_mask,
  output logic [NUM_SW-1:0] sw_q,
  output logic [NUM_SW-1:0] sw_rst
);
  localparam logic [NUM_SW-1:0] POL = SW_ACT_LOW[NUM_SW-1:0];
  logic [NUM_SW-1:0] sw_d;

  always_comb begin
    for (int i = 0; i < NUM_SW; i++) begin
      sw_d[i] = sw_mask[i] ? sw_data[i] : sw_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= POL;   // released state for every line
    else if (wr_en) sw_q <= sw_d;
  end

  // asserted when stored bit differs from the release value
  assign sw_rst = sw_q ^ POL;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rstseq_pkg::*;
#(
  parameter int          NUM_DOM    = 4,
  parameter int          NUM_SW     = 8,
  parameter int          CNT_W      = 4,
  parameter int          ADDR_W     = 4,
  parameter int          DONE_LSB   = 28,
  parameter int          DLY_RST    = 4,
  parameter int          HOLD_RST   = 8,
  parameter logic [15:0] SW_ACT_LOW = 16'h000F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_DOM-1:0] dom_rst,
  output logic [NUM_DOM-1:0] dom_done,
  output logic [NUM_SW-1:0]  sw_rst
);
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_SW   = 1;
  localparam int TIM_BASE  = 2;

  logic               wr_ctrl, wr_sw;
  logic [NUM_DOM-1:0] wr_tim;
  logic [NUM_DOM-1:0] req_q, dom_busy, dom_start, dom_fin;
  logic [NUM_SW-1:0]  sw_q;
  logic [CNT_W-1:0]   dly_q  [NUM_DOM];
  logic [CNT_W-1:0]   hold_q [NUM_DOM];
  logic [31:0]        tim_word [NUM_DOM];
  logic [31:0]        ctrl_word;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_sw   = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_SW));

  rst_ctrl_reg #(.NUM_DOM(NUM_DOM)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ctrl),
    .req_data (bus_wdata[NUM_DOM-1:0]),
    .req_mask (bus_wdata[MASK_OFS +: NUM_DOM]),
    .done_clr (bus_wdata[DONE_LSB +: NUM_DOM]),
    .busy_i   (dom_busy),
    .start_i  (dom_start),
    .fin_i    (dom_fin),
    .req_q    (req_q),
    .done_q   (dom_done)
  );

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    assign wr_tim[i] = bus_sel && bus_wr && (bus_addr == ADDR_W'(TIM_BASE + i));

    rst_tim_reg #(
      .CNT_W    (CNT_W),
      .DLY_RST  (DLY_RST),
      .HOLD_RST (HOLD_RST)
    ) u_tim (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_tim[i]),
      .dly_wr  (bus_wdata[DLY_LSB +: CNT_W]),
      .hold_wr (bus_wdata[HOLD_LSB +: CNT_W]),
      .dly_q   (dly_q[i]),
      .hold_q  (hold_q[i])
    );

    rst_seq_unit #(.CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_q[i]),
      .dly_i   (dly_q[i]),
      .hold_i  (hold_q[i]),
      .start_o (dom_start[i]),
      .busy_o  (dom_busy[i]),
      .rst_o   (dom_rst[i]),
      .fin_o   (dom_fin[i])
    );

    always_comb begin
      tim_word[i] = '0;
      tim_word[i][DLY_LSB +: CNT_W]  = dly_q[i];
      tim_word[i][HOLD_LSB +: CNT_W] = hold_q[i];
    end
  end

  rst_sw_reg #(
    .NUM_SW     (NUM_SW),
    .SW_ACT_LOW (SW_ACT_LOW)
  ) u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_sw),
    .sw_data (bus_wdata[NUM_SW-1:0]),
    .sw_mask (bus_wdata[MASK_OFS +: NUM_SW]),
    .sw_q    (sw_q),
    .sw_rst  (sw_rst)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[NUM_DOM-1:0]         = req_q;
    ctrl_word[DONE_LSB +: NUM_DOM] = dom_done;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(ADDR_CTRL)) bus_rdata = ctrl_word;
      if (bus_addr == ADDR_W'(ADDR_SW))   bus_rdata[NUM_SW-1:0] = sw_q;
      for (int i = 0; i < NUM_DOM; i++) begin
        if (bus_addr == ADDR_W'(TIM_BASE + i)) bus_rdata = tim_word[i];
      end
    end
  end
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int NUM_DOM = 4,
  parameter int NUM_SW  = 8,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [NUM_DOM-1:0] dom_rst,
  input logic [NUM_DOM-1:0] dom_done,
  input logic [NUM_DOM-1:0] dom_busy,
  input logic [NUM_DOM-1:0] req_q,
  input logic [NUM_SW-1:0]  sw_rst
);
  logic ctrl_wr, sw_wr;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == '0);
  assign sw_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_a
    // R3: reset only while the sequencer is active
    a_r3_rst_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      dom_rst[i] |-> dom_busy[i]);
    // R4: release coincides with completion
    a_r4_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_rst[i]) |-> dom_done[i]);
    // R6: request lasts one cycle
    a_r6_req_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[i] |=> !req_q[i]);
    // R7: no pending request while running
    a_r7_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      dom_busy[i] |-> !req_q[i]);
    // R2: unmasked write cannot raise a request
    a_r2_mask_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !bus_wdata[16+i] && !req_q[i]) |=> !req_q[i]);
  end

  // R10: software lines move only on a write to their register
  a_r10_sw_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> $stable(sw_rst));
endmodule

bind rst_seq_ctrl rst_seq_chk #(
  .NUM_DOM (NUM_DOM),
  .NUM_SW  (NUM_SW),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dom_rst   (dom_rst),
  .dom_done  (dom_done),
  .dom_busy  (dom_busy),
  .req_q     (req_q),
  .sw_rst    (sw_rst)
);

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  dom_rst, dom_done;
  logic [7:0]  sw_rst;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;

  typedef struct { int dom; int rise; int fall; } exp_t;
  exp_t expq[$];
  int tim_d[4];
  int tim_h[4];
  int last_fall[4];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dom_rst(dom_rst), .dom_done(dom_done), .sw_rst(sw_rst)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    w = cyc;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // driver: write a request and push the expected pulses
  task automatic req_doms(input logic [3:0] bits);
    int w;
    wr(4'd0, {12'h0, bits, 12'h0, bits}, w);
    for (int d = 0; d < 4; d++) begin
      if (bits[d] && w > last_fall[d]) begin
        exp_t e;
        e.dom  = d;
        e.rise = w + 1 + eff(tim_d[d]);
        e.fall = e.rise + eff(tim_h[d]);
        last_fall[d] = e.fall;
        expq.push_back(e);
      end
    end
  endtask

  // monitor: compare every observed pulse against the queue
  logic [3:0] prev_rst = '0;
  int rise_at[4];
  always @(negedge clk) begin
    for (int d = 0; d < 4; d++) begin
      if (dom_rst[d] && !prev_rst[d]) rise_at[d] = cyc;
      if (!dom_rst[d] && prev_rst[d]) begin : fall_blk
        int idx;
        idx = -1;
        for (int k = 0; k < expq.size(); k++)
          if (idx < 0 && expq[k].dom == d) idx = k;
        if (idx < 0) begin
          chk(1'b0, "R7 unexpected reset pulse", d, 32'hFFFF_FFFF);
        end else begin
          chk(rise_at[d] == expq[idx].rise, "R3 assert cycle", rise_at[d], expq[idx].rise);
          chk(cyc == expq[idx].fall, "R3 release cycle", cyc, expq[idx].fall);
          chk(dom_done[d] == 1'b1, "R4 done at release", dom_done[d], 1);
          expq.delete(idx);
        end
      end
    end
    prev_rst = dom_rst;
  end

  initial begin
    #(200000 * 10);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int w;
    for (int d = 0; d < 4; d++) begin
      tim_d[d] = 4; tim_h[d] = 8; last_fall[d] = -1;
    end
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(dom_rst == 4'h0, "R1 dom_rst idle", dom_rst, 0);
    chk(dom_done == 4'h0, "R1 done clear", dom_done, 0);
    chk(sw_rst == 8'h00, "R1 sw lines released", sw_rst, 0);
    rd(4'd0, r); chk(r == 32'h0, "R1 control reads 0", r, 0);
    rd(4'd2, r); chk(r == 32'h0008_0400, "R1 timing default", r, 32'h0008_0400);
    rd(4'd1, r); chk(r == 32'h0000_000F, "R1 sw register default", r, 32'h0F);

    // R9 timing fields
    wr(4'd3, 32'hA5A5_32C7, w);
    tim_d[1] = 2; tim_h[1] = 5;
    rd(4'd3, r); chk(r == 32'h0005_0200, "R9 timing fields only", r, 32'h0005_0200);

    // R3 / R11 two domains at once, R6 request readback
    req_doms(4'b0011);
    bus_addr = 4'd0; #1;
    chk(bus_rdata[1:0] == 2'b11, "R6 request visible", bus_rdata[1:0], 2'b11);
    rd(4'd0, r); chk(r[3:0] == 4'h0, "R6 request self-cleared", r[3:0], 0);

    // R7 repeat request during the run
    repeat (4) @(negedge clk);
    req_doms(4'b0001);
    bus_addr = 4'd0; #1;
    chk(bus_rdata[0] == 1'b0, "R7 busy request dropped", bus_rdata[0], 0);

    // R2 unmasked request does nothing
    wr(4'd0, 32'h0000_0004, w);
    bus_addr = 4'd0; #1;
    chk(bus_rdata[2] == 1'b0, "R2 unmasked request ignored", bus_rdata[2], 0);

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R11 both pulses seen", expq.size(), 0);
    rd(4'd0, r); chk(r == 32'h3000_0000, "R4 done flags set", r, 32'h3000_0000);

    // R4 / R5 completion flag clearing
    wr(4'd0, 32'h0000_0000, w);
    rd(4'd0, r); chk(r == 32'h3000_0000, "R4 write 0 keeps done", r, 32'h3000_0000);
    wr(4'd0, 32'h2000_0000, w);
    rd(4'd0, r); chk(r == 32'h1000_0000, "R5 clear one done", r, 32'h1000_0000);

    // R7 request after completion is accepted
    req_doms(4'b0001);
    repeat (16) @(negedge clk);
    chk(expq.size() == 0, "R7 new run after release", expq.size(), 0);

    // R8 zero counts
    wr(4'd4, 32'h0000_0000, w);
    tim_d[2] = 0; tim_h[2] = 0;
    rd(4'd4, r); chk(r == 32'h0, "R9 timing written zero", r, 0);
    req_doms(4'b0100);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R8 one-cycle minimum pulse", expq.size(), 0);
    rd(4'd0, r); chk(r[30] == 1'b1, "R8 done after short pulse", r[30], 1);

    // R10 software lines
    wr(4'd1, 32'hFFFF_00F0, w);
    chk(sw_rst == 8'hFF, "R10 assert all, both polarities", sw_rst, 8'hFF);
    wr(4'd1, 32'h0001_0001, w);
    chk(sw_rst == 8'hFE, "R10 masked release bit 0", sw_rst, 8'hFE);
    rd(4'd1, r); chk(r == 32'h0000_00F1, "R10 stored value", r, 32'hF1);
    wr(4'd1, 32'h0000_00FF, w);
    chk(sw_rst == 8'hFE, "R10 unmasked write ignored", sw_rst, 8'hFE);
    wr(4'd1, 32'h00FF_000F, w);
    chk(sw_rst == 8'h00, "R10 release all", sw_rst, 8'h00);

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    chk(dom_rst == 4'h0, "R3 all released", dom_rst, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule